// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. After reset it holds the strobes idle for a power-on pause. It then runs a fixed number of wake-up cycles, each one a CAS-before-RAS refresh. Once those are done it raises a ready flag that hands the memory to the access controller. From then on an interval timer creates one refresh obligation per period. The period is chosen so that the full set of rows is refreshed well inside the retention window.

Every refresh, including the wake-up ones, needs the bus. The sequencer asks the access controller for it with a request line and starts a cycle only on a grant. While a grant is held back, the obligations pile up in an owed counter. Past a threshold, an urgent flag tells the controller to close its open row at the next legal point. If the owed count ever reaches its limit, the retention deadline counts as missed. The ready flag then drops, the backlog is discarded, and the whole wake-up sequence runs again.

All waits are given in clock cycles through parameters. These are the pause, the CAS setup before RAS, the CAS hold after RAS, the RAS active width, the precharge and the refresh interval. The device's internal row counter supplies row addresses, so the block drives no address.

Top module: `dram_ref_seq`

## Requirements
- R1: After reset, for PAUSE_CYC cycles, rasN and casN stay high and memReady and refReq stay low.
- R2: After the pause, WAKE_CNT refresh cycles run, each waiting for a grant. memReady rises in the cycle after the last wake-up cycle's final RAS-low cycle.
- R3: Each refresh drives casN low for CSR_CYC cycles with rasN high, and only then drives rasN low. casN stays low for the first CHR_CYC cycles of the RAS-low period.
- R4: rasN stays low for exactly RAS_CYC cycles and rises with casN high. Both strobes then stay high for RP_CYC cycles before the cycle ends.
- R5: While memReady is high, one refresh becomes owed every REF_INTERVAL cycles. The first one comes REF_INTERVAL cycles after memReady rises.
- R6: Outside the pause, refReq is high whenever a refresh is owed, a wake-up cycle is pending, or a refresh cycle is in progress. A cycle starts only in an idle cycle where refGrant is sampled high. Once started, a cycle runs to completion even if refGrant falls.
- R7: refUrgent is high exactly when memReady is high and the owed count is at least URGENT_TH.
- R8: If a new obligation would bring the owed count to OWE_LIMIT, memReady falls at once and the owed count clears. WAKE_CNT wake-up cycles are then required again before memReady returns.
- R9: A completed refresh outside the wake-up sequence reduces the owed count by one. If it coincides with a new obligation, the count stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGrant | input | 1 | Bus grant from the access controller |
| refReq | output | 1 | Bus request to the access controller |
| refUrgent | output | 1 | Owed refreshes at or above threshold; close the open row |
| memReady | output | 1 | Memory initialised; normal accesses allowed |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low; drive to both byte strobes |

## Verification
The bench first holds the grant permanently high. This shows the bare strobe timing, the wake-up count and the steady one-refresh-per-interval rhythm. It then grants on a duty-cycled pattern that drops the grant partway through cycles. This separates "start only on grant" from "never abort once started" and makes obligations coincide with completions. It then withholds the grant long enough to pass the urgent threshold and reach the owed limit. The ready flag must drop, and after the grant returns, exactly the wake-up number of RAS cycles must occur before the ready flag comes back.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    PH_PAUSE,
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_PRECH
  } phase_e;

  // strobes from the control FSM to the bookkeeping datapath
  typedef struct packed {
    logic retire;  // last RAS-low cycle of a refresh
    logic busy;    // a refresh cycle is in progress
    logic paused;  // still in the power-on pause
  } seqStrobe_t;

endpackage

// File: rtl/dram_ref_ctrl.sv
module dram_ref_ctrl
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYC = 20,
  parameter int CSR_CYC   = 2,
  parameter int CHR_CYC   = 2,
  parameter int RAS_CYC   = 4,
  parameter int RP_CYC    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGrant,
  input  logic       workPending,
  output seqStrobe_t strobe,
  output logic       rasN,
  output logic       casN
);

  localparam int MAX_A = (PAUSE_CYC > RAS_CYC) ? PAUSE_CYC : RAS_CYC;
  localparam int MAX_B = (CSR_CYC > RP_CYC) ? CSR_CYC : RP_CYC;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = (MAX_T > 1) ? $clog2(MAX_T) : 1;

  phase_e          state, nxtState;
  logic [TW-1:0]   timer, nxtTimer;
  logic            timerDone;

  assign timerDone = (timer == '0);

  always_comb begin
    nxtState = state;
    nxtTimer = timerDone ? timer : timer - 1'b1;
    case (state)
      PH_PAUSE:  if (timerDone) nxtState = PH_IDLE;
      PH_IDLE:   if (workPending && refGrant) begin
                   nxtState = PH_SETUP;
                   nxtTimer = TW'(CSR_CYC - 1);
                 end
      PH_SETUP:  if (timerDone) begin
                   nxtState = PH_ACTIVE;
                   nxtTimer = TW'(RAS_CYC - 1);
                 end
      PH_ACTIVE: if (timerDone) begin
                   nxtState = PH_PRECH;
                   nxtTimer = TW'(RP_CYC - 1);
                 end
      PH_PRECH:  if (timerDone) nxtState = PH_IDLE;
      default:   nxtState = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PH_PAUSE;
      timer <= TW'(PAUSE_CYC - 1);
    end else begin
      state <= nxtState;
      timer <= nxtTimer;
    end
  end

  assign rasN = (state != PH_ACTIVE);
  assign casN = !((state == PH_SETUP) ||
                  ((state == PH_ACTIVE) && (timer >= TW'(RAS_CYC - CHR_CYC))));

  assign strobe.retire = (state == PH_ACTIVE) && timerDone;
  assign strobe.busy   = (state == PH_SETUP) || (state == PH_ACTIVE) || (state == PH_PRECH);
  assign strobe.paused = (state == PH_PAUSE);

  // R3
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> $past(!casN));

  // R4
  ras_rise_cas_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> casN);

  // R6
  start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_SETUP && $past(state) == PH_IDLE) |-> $past(refGrant));

  // R1
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.paused |-> (rasN && casN));

endmodule

// File: rtl/dram_ref_data.sv
module dram_ref_data
  import dram_ref_pkg::*;
#(
  parameter int WAKE_CNT     = 8,
  parameter int REF_INTERVAL = 40,
  parameter int OWE_LIMIT    = 6,
  parameter int URGENT_TH    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       workPending,
  output logic       refReq,
  output logic       refUrgent,
  output logic       memReady
);

  localparam int IW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam int OW = $clog2(OWE_LIMIT + 1);
  localparam int WW = $clog2(WAKE_CNT + 1);

  logic [IW-1:0] interval;
  logic [OW-1:0] owed;
  logic [WW-1:0] wakeLeft;
  logic [OW:0]   owedSum;
  logic          tick, retireOwed, deadlineMiss;

  assign tick         = memReady && (interval == '0);
  assign retireOwed   = strobe.retire && (wakeLeft == '0);
  assign owedSum      = {1'b0, owed} + (OW+1)'(tick) - (OW+1)'(retireOwed);
  assign deadlineMiss = (owedSum == (OW+1)'(OWE_LIMIT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      interval <= IW'(REF_INTERVAL - 1);
      owed     <= '0;
      wakeLeft <= WW'(WAKE_CNT);
      memReady <= 1'b0;
    end else begin
      if (!memReady || tick) interval <= IW'(REF_INTERVAL - 1);
      else                   interval <= interval - 1'b1;

      if (deadlineMiss) begin
        owed     <= '0;
        wakeLeft <= WW'(WAKE_CNT);
        memReady <= 1'b0;
      end else begin
        owed <= owedSum[OW-1:0];
        if (strobe.retire && wakeLeft != '0) begin
          wakeLeft <= wakeLeft - 1'b1;
          if (wakeLeft == WW'(1)) memReady <= 1'b1;
        end
      end
    end
  end

  assign workPending = (wakeLeft != '0) || (owed != '0);
  assign refReq      = !strobe.paused && (strobe.busy || workPending);
  assign refUrgent   = memReady && (owed >= OW'(URGENT_TH));

  // R8
  owed_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    owed < OW'(OWE_LIMIT));

  // R2
  ready_after_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReady) |-> $past(strobe.retire));

  // R7
  urgent_requests_chk: assert property (@(posedge clk) disable iff (!rstN)
    refUrgent |-> refReq);

  // R9
  owed_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReady && $past(memReady) && !$past(tick)) |-> (owed <= $past(owed)));

endmodule

// File: rtl/dram_ref_seq.sv
module dram_ref_seq
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYC    = 20,
  parameter int WAKE_CNT     = 8,
  parameter int REF_INTERVAL = 40,
  parameter int CSR_CYC      = 2,
  parameter int CHR_CYC      = 2,
  parameter int RAS_CYC      = 4,
  parameter int RP_CYC       = 3,
  parameter int OWE_LIMIT    = 6,
  parameter int URGENT_TH    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  output logic refReq,
  output logic refUrgent,
  output logic memReady,
  output logic rasN,
  output logic casN
);

  seqStrobe_t strobe;
  logic       workPending;

  dram_ref_ctrl #(
    .PAUSE_CYC(PAUSE_CYC), .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC),
    .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .workPending(workPending),
    .strobe(strobe), .rasN(rasN), .casN(casN)
  );

  dram_ref_data #(
    .WAKE_CNT(WAKE_CNT), .REF_INTERVAL(REF_INTERVAL),
    .OWE_LIMIT(OWE_LIMIT), .URGENT_TH(URGENT_TH)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .workPending(workPending),
    .refReq(refReq), .refUrgent(refUrgent), .memReady(memReady)
  );

endmodule

// File: tb/dram_ref_seq_bench.sv
module dram_ref_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PAUSE = 20, WAKE = 8, INTV = 40, CSR = 2, CHR = 2;
  localparam int RASW = 4, RP = 3, OWE = 6, URG = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic refReq, refUrgent, memReady, rasN, casN;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  dram_ref_seq #(
    .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .REF_INTERVAL(INTV), .CSR_CYC(CSR),
    .CHR_CYC(CHR), .RAS_CYC(RASW), .RP_CYC(RP), .OWE_LIMIT(OWE), .URGENT_TH(URGENT_TH_V)
  ) u_dram_ref_seq (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq),
    .refUrgent(refUrgent), .memReady(memReady), .rasN(rasN), .casN(casN)
  );
  localparam int URGENT_TH_V = URG;

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: phase 0 pause,1 idle,2 setup,3 active,4 precharge
  int mPhase = 0, mEl = 0, mWake = WAKE, mOwed = 0, mTick = 0, owedNext = 0;
  bit mReady = 1'b0, mRetire, mTickHit, mStart;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mEl = 0; mWake = WAKE; mOwed = 0; mReady = 0; mTick = 0;
    end else begin
      mRetire  = (mPhase == 3) && (mEl == RASW - 1);
      mTickHit = mReady && (mTick == INTV - 1);
      mStart   = (mPhase == 1) && (mWake > 0 || mOwed > 0) && refGrant;
      case (mPhase)
        0: if (mEl == PAUSE - 1) begin mPhase = 1; mEl = 0; end else mEl++;
        1: if (mStart) begin mPhase = 2; mEl = 0; end
        2: if (mEl == CSR - 1) begin mPhase = 3; mEl = 0; end else mEl++;
        3: if (mEl == RASW - 1) begin mPhase = 4; mEl = 0; end else mEl++;
        default: if (mEl == RP - 1) begin mPhase = 1; mEl = 0; end else mEl++;
      endcase
      if (mReady) mTick = mTickHit ? 0 : mTick + 1;
      else        mTick = 0;
      owedNext = mOwed + (mTickHit ? 1 : 0) - ((mRetire && mWake == 0) ? 1 : 0);
      if (owedNext == OWE) begin
        mOwed = 0; mWake = WAKE; mReady = 0;
      end else begin
        mOwed = owedNext;
        if (mRetire && mWake > 0) begin
          if (mWake == 1) mReady = 1;
          mWake--;
        end
      end
    end
  end

  task automatic checkBit(input string req, input string name, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  bit cmpOn = 1'b0;
  int casLowRun = 0, rasFalls = 0, missSeen = 0;
  logic prevRas = 1'b1, prevReady = 1'b0, prevCas = 1'b1;
  bit firstReadyDone = 1'b0;

  always @(negedge clk) begin
    if (cmpOn) begin
      // R3 R4
      checkBit("R4", "rasN", rasN, !(mPhase == 3));
      checkBit("R3", "casN", casN, !(mPhase == 2 || (mPhase == 3 && mEl < CHR)));
      // R2 R8
      checkBit("R2/R8", "memReady", memReady, mReady);
      // R6 R9
      checkBit("R6", "refReq", refReq, (mPhase != 0) && (mPhase != 1 || mWake > 0 || mOwed > 0));
      // R7 R5
      checkBit("R7", "refUrgent", refUrgent, mReady && (mOwed >= URG));
      // R3: independent ordering check at every rasN fall
      if (prevRas && !rasN)
        checkBit("R3", "casN low for setup before rasN fall", casLowRun >= CSR, 1'b1);
      if (prevRas && !rasN) rasFalls++;
      // R2: wake-up count at the first ready rise
      if (!prevReady && memReady) begin
        checkBit(firstReadyDone ? "R8" : "R2", "wake-up cycle count ok",
                 rasFalls == WAKE, 1'b1);
        if (rasFalls != WAKE) $display("FAIL R2 rasFalls actual=%0d expected=%0d", rasFalls, WAKE);
        firstReadyDone = 1'b1;
      end
      if (prevReady && !memReady) begin
        missSeen++;
        rasFalls = 0;
      end
      casLowRun = casN ? 0 : ((rasN) ? casLowRun + 1 : casLowRun);
      prevRas = rasN;
      prevReady = memReady;
      prevCas = casN;
    end
  end

  task automatic runGrant(input int mode, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (mode)
        0: refGrant = 1'b0;
        1: refGrant = 1'b1;
        default: refGrant = (i % 5 == 1) || (i % 5 == 2);
      endcase
    end
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkBit("R1", "rasN after reset", rasN, 1'b1);
    checkBit("R1", "casN after reset", casN, 1'b1);
    checkBit("R1", "memReady after reset", memReady, 1'b0);
    checkBit("R1", "refReq during pause", refReq, 1'b0);
    cmpOn = 1'b1;
    runGrant(1, 400);          // wake-up and steady refresh (R2, R5)
    runGrant(2, 600);          // duty-cycled grant, drops mid-cycle (R6, R9)
    runGrant(0, 320);          // starve: urgent then deadline miss (R7, R8)
    // R8: deadline miss observed
    checkBit("R8", "ready dropped on deadline miss", missSeen > 0, 1'b1);
    checkBit("R8", "ready low after miss", memReady, 1'b0);
    runGrant(1, 400);          // recovery: wake-up again (R8)
    checkBit("R8", "ready back after re-wake", memReady, 1'b1);
    runGrant(1, 20);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule